// File: doc/BRIEF.md
# UART Host Register Interface

This block is the bus-facing half of a serial port. A host processor reaches it through a Wishbone-style slave port with a 16-bit data bus, a small address bus and one select bit per byte lane. Behind the port the block keeps the configuration that the serial engines need: a line-control byte, an interrupt-enable mask and a 16-bit baud divisor. It also holds the byte waiting to be sent and the byte last received. It tracks receive-side line errors and merges the enabled event sources into one interrupt request.

The shift engines sit outside the block. The receiver presents each finished byte with a one-cycle valid pulse and optional parity and framing error flags. The transmitter takes the pending byte with a one-cycle take pulse. Two active-low pins tell a DMA engine or simple poller whether a byte may be written or is waiting to be read.

Top module: `uart_regif`

## Requirements
- R1: An access is taken when `cyc_i` and `stb_i` are both high. `ack_o` rises on the clock after that and stays high for exactly one cycle. No `ack_o` appears while either `cyc_i` or `stb_i` is low.
- R2: A read returns the addressed register, zero-extended, on `dat_o` in the cycle where `ack_o` is high. An unmapped address reads as zero.
- R3: The 16-bit divisor sits at address 0x7. `sel_i[0]` writes bits 7:0 and `sel_i[1]` writes bits 15:8, so select 0b11 loads the whole value in one access. It resets to `DIV_RESET` (0x0036) and drives `div_o`.
- R4: The interrupt mask sits at 0x1 (3 bits) and the line-control byte at 0x3 (drives `lcr_o`). Both are written only when `sel_i[0]` is set. Writes to read-only addresses (0x0, 0x2, 0x5) change nothing.
- R5: A write to 0x8 with `sel_i[0]` loads `tx_data_o`, clears the holding-empty bit (status bit 5) and drives `txrdy_n` high. A `tx_take_i` pulse sets the bit again.
- R6: A `rx_valid_i` pulse stores `rx_data_i`, sets data-ready (status bit 0) and drives `rxrdy_n` low. A read at 0x0 returns the byte and clears data-ready.
- R7: Status bit 1 flags a byte that arrives while data-ready is still set. Bits 2 and 3 capture `rx_perr_i` and `rx_ferr_i`. A read of the status at 0x5 returns these bits and then clears bits 1 to 3.
- R8: `irq_o` is the registered OR of each pending source ANDed with its mask bit. Mask bit 0 enables data-ready, bit 1 enables holding-empty, and bit 2 enables any line error.
- R9: The identification register at 0x2 reads 0x01 when no enabled source is pending. Otherwise it reads 0x06 for a line error, 0x04 for data-ready and 0x02 for holding-empty, with the first of these that applies taking precedence.
- R10: After reset, `ack_o`, `irq_o` and `dat_o` are 0, `txrdy_n` is low and `rxrdy_n` is high. The mask, line-control and status error bits are clear.
- R11: When a byte arrives in the same cycle as a receive-buffer read, the read returns the old byte. The new byte is kept and data-ready stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe, qualifies an access |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Register address |
| sel_i | input | DATA_W/8 | Byte-lane selects |
| dat_i | input | DATA_W | Write data |
| dat_o | output | DATA_W | Read data, valid with ack_o |
| ack_o | output | 1 | One-cycle access acknowledge |
| irq_o | output | 1 | Combined interrupt request |
| rx_data_i | input | 8 | Byte from the receiver |
| rx_valid_i | input | 1 | Receiver byte pulse |
| rx_perr_i | input | 1 | Parity error with the byte |
| rx_ferr_i | input | 1 | Framing error with the byte |
| tx_take_i | input | 1 | Transmitter took the pending byte |
| tx_data_o | output | 8 | Pending transmit byte |
| lcr_o | output | 8 | Line-control setting |
| div_o | output | DATA_W | Baud divisor |
| txrdy_n | output | 1 | Low while a byte may be written |
| rxrdy_n | output | 1 | Low while a byte waits to be read |

## Verification
Register decoding is tried with full, partial and empty lane selects. This separates a lane-gated write from one that ignores the selects, and a read-only address from a writable one. Status behaviour is tried with single bytes, back-to-back bytes with an error flag, and a byte that lands in the same cycle as a buffer read. These cases separate overrun detection, read-to-clear and same-cycle precedence. The interrupt tests step through each mask setting while one, two or three sources are pending, which exposes a wrong priority order or a source that bypasses its mask.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int BYTE_W = 8;

  // address map (host view)
  localparam logic [3:0] A_RXBUF = 4'h0;
  localparam logic [3:0] A_IMASK = 4'h1;
  localparam logic [3:0] A_IDENT = 4'h2;
  localparam logic [3:0] A_LCTRL = 4'h3;
  localparam logic [3:0] A_LSTAT = 4'h5;
  localparam logic [3:0] A_BAUD  = 4'h7;
  localparam logic [3:0] A_TXBUF = 4'h8;

  // interrupt mask bits
  localparam int M_RXRDY = 0;
  localparam int M_TXEMP = 1;
  localparam int M_LERR  = 2;
  localparam int MASK_W  = 3;

  // identification codes
  localparam logic [7:0] ID_NONE  = 8'h01;
  localparam logic [7:0] ID_LERR  = 8'h06;
  localparam logic [7:0] ID_RXRDY = 8'h04;
  localparam logic [7:0] ID_TXEMP = 8'h02;
endpackage

// File: rtl/uart_regif_bus.sv
module uart_regif_bus #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o
);
  logic take;

  // a new access is taken only while no acknowledge is outstanding
  assign take = cyc_i && stb_i && !ack_o;
  assign wr_o = take && we_i;
  assign rd_o = take && !we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= take;
      dat_o <= rd_o ? rdata_i : '0;
    end
  end
endmodule

// File: rtl/uart_regif_status.sv
module uart_regif_status
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  input  logic              tx_take_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rbr_rd_i,
  input  logic              lsr_rd_i,
  output logic [BYTE_W-1:0] rbr_o,
  output logic [BYTE_W-1:0] thr_o,
  output logic [BYTE_W-1:0] lsr_o,
  output logic              dr_o,
  output logic              thre_o,
  output logic              lerr_o
);
  logic dr_q, thre_q, oe_q, pe_q, fe_q;
  logic oe_set;

  // a byte landing while the last one is unread, unless that read is happening now
  assign oe_set = rx_valid_i && dr_q && !rbr_rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbr_o  <= '0;
      thr_o  <= '0;
      dr_q   <= 1'b0;
      thre_q <= 1'b1;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (thr_wr_i) begin
        thr_o  <= wbyte_i;
        thre_q <= 1'b0;
      end else if (tx_take_i) begin
        thre_q <= 1'b1;
      end

      if (rx_valid_i) begin
        rbr_o <= rx_data_i;
        dr_q  <= 1'b1;
      end else if (rbr_rd_i) begin
        dr_q  <= 1'b0;
      end

      // fresh events win over the read-to-clear of the same cycle
      oe_q <= (oe_q && !lsr_rd_i) || oe_set;
      pe_q <= (pe_q && !lsr_rd_i) || (rx_valid_i && rx_perr_i);
      fe_q <= (fe_q && !lsr_rd_i) || (rx_valid_i && rx_ferr_i);
    end
  end

  assign lsr_o  = {2'b00, thre_q, 1'b0, fe_q, pe_q, oe_q, dr_q};
  assign dr_o   = dr_q;
  assign thre_o = thre_q;
  assign lerr_o = oe_q || pe_q || fe_q;
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              dr_i,
  input  logic              thre_i,
  input  logic              lerr_i,
  output logic [BYTE_W-1:0] ident_o,
  output logic              irq_o
);
  logic [MASK_W-1:0] src, live;

  always_comb begin
    src          = '0;
    src[M_RXRDY] = dr_i;
    src[M_TXEMP] = thre_i;
    src[M_LERR]  = lerr_i;
    live         = src & mask_i;
  end

  // fixed precedence: line error, then received data, then transmit room
  always_comb begin
    if (live[M_LERR])       ident_o = ID_LERR;
    else if (live[M_RXRDY]) ident_o = ID_RXRDY;
    else if (live[M_TXEMP]) ident_o = ID_TXEMP;
    else                    ident_o = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |live;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int               DATA_W    = 16,
  parameter int               ADDR_W    = 4,
  parameter logic [DATA_W-1:0] DIV_RESET = 16'h0036
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cyc_i,
  input  logic                     stb_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        adr_i,
  input  logic [DATA_W/BYTE_W-1:0] sel_i,
  input  logic [DATA_W-1:0]        dat_i,
  output logic [DATA_W-1:0]        dat_o,
  output logic                     ack_o,
  output logic                     irq_o,
  input  logic [BYTE_W-1:0]        rx_data_i,
  input  logic                     rx_valid_i,
  input  logic                     rx_perr_i,
  input  logic                     rx_ferr_i,
  input  logic                     tx_take_i,
  output logic [BYTE_W-1:0]        tx_data_o,
  output logic [BYTE_W-1:0]        lcr_o,
  output logic [DATA_W-1:0]        div_o,
  output logic                     txrdy_n,
  output logic                     rxrdy_n
);
  localparam int LANES = DATA_W / BYTE_W;

  logic              wr, rd;
  logic [DATA_W-1:0] rdata;
  logic [MASK_W-1:0] ier_q;
  logic [BYTE_W-1:0] lcr_q;
  logic [DATA_W-1:0] div_q;
  logic [BYTE_W-1:0] rbr, thr, lsr, ident;
  logic              dr, thre, lerr;
  logic              hit_rx, hit_im, hit_id, hit_lc, hit_ls, hit_bd, hit_tx;

  assign hit_rx = adr_i == ADDR_W'(A_RXBUF);
  assign hit_im = adr_i == ADDR_W'(A_IMASK);
  assign hit_id = adr_i == ADDR_W'(A_IDENT);
  assign hit_lc = adr_i == ADDR_W'(A_LCTRL);
  assign hit_ls = adr_i == ADDR_W'(A_LSTAT);
  assign hit_bd = adr_i == ADDR_W'(A_BAUD);
  assign hit_tx = adr_i == ADDR_W'(A_TXBUF);

  uart_regif_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .rdata_i(rdata), .wr_o(wr), .rd_o(rd), .ack_o(ack_o), .dat_o(dat_o)
  );

  // byte-wide configuration registers use the low lane only
  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
      lcr_q <= '0;
    end else if (wr && sel_i[0]) begin
      if (hit_im) ier_q <= dat_i[MASK_W-1:0];
      if (hit_lc) lcr_q <= dat_i[BYTE_W-1:0];
    end
  end

  // divisor: one flop group per byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_div_lane
    always_ff @(posedge clk) begin
      if (rst)
        div_q[g*BYTE_W +: BYTE_W] <= DIV_RESET[g*BYTE_W +: BYTE_W];
      else if (wr && hit_bd && sel_i[g])
        div_q[g*BYTE_W +: BYTE_W] <= dat_i[g*BYTE_W +: BYTE_W];
    end
  end

  uart_regif_status u_stat (
    .clk(clk), .rst(rst),
    .thr_wr_i(wr && hit_tx && sel_i[0]), .wbyte_i(dat_i[BYTE_W-1:0]),
    .tx_take_i(tx_take_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_perr_i(rx_perr_i), .rx_ferr_i(rx_ferr_i),
    .rbr_rd_i(rd && hit_rx), .lsr_rd_i(rd && hit_ls),
    .rbr_o(rbr), .thr_o(thr), .lsr_o(lsr),
    .dr_o(dr), .thre_o(thre), .lerr_o(lerr)
  );

  uart_regif_irq u_irq (
    .clk(clk), .rst(rst), .mask_i(ier_q),
    .dr_i(dr), .thre_i(thre), .lerr_i(lerr),
    .ident_o(ident), .irq_o(irq_o)
  );

  always_comb begin
    rdata = '0;
    if (hit_rx)      rdata = DATA_W'(rbr);
    else if (hit_im) rdata = DATA_W'(ier_q);
    else if (hit_id) rdata = DATA_W'(ident);
    else if (hit_lc) rdata = DATA_W'(lcr_q);
    else if (hit_ls) rdata = DATA_W'(lsr);
    else if (hit_bd) rdata = div_q;
  end

  assign tx_data_o = thr;
  assign lcr_o     = lcr_q;
  assign div_o     = div_q;
  assign txrdy_n   = !thre;
  assign rxrdy_n   = !dr;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_i,
  input logic              stb_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] adr_i,
  input logic              sel0,
  input logic              ack_o,
  input logic              rx_valid_i,
  input logic              txrdy_n,
  input logic              rxrdy_n,
  input logic              irq_o,
  input logic [DATA_W-1:0] div_o,
  input logic [2:0]        ier_q
);
  logic wr_take;
  assign wr_take = cyc_i && stb_i && we_i && !ack_o;

  // R1
  ack_source_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(cyc_i && stb_i));

  // R1
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_take && adr_i == ADDR_W'(4'h7))) |-> $stable(div_o));

  // R5
  txrdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txrdy_n) |-> $past(wr_take && sel0 && adr_i == ADDR_W'(4'h8)));

  // R6
  rxrdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rxrdy_n) |-> $past(rx_valid_i));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ier_q != 3'b000));
endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
  .adr_i(adr_i), .sel0(sel_i[0]), .ack_o(ack_o), .rx_valid_i(rx_valid_i),
  .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .irq_o(irq_o), .div_o(div_o),
  .ier_q(ier_q)
);

// File: tb/uart_regif_test.sv
module uart_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 0, stb_i = 0, we_i = 0;
  logic [3:0]  adr_i = '0;
  logic [1:0]  sel_i = '0;
  logic [15:0] dat_i = '0;
  logic [15:0] dat_o;
  logic        ack_o, irq_o;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 0, rx_perr_i = 0, rx_ferr_i = 0, tx_take_i = 0;
  logic [7:0]  tx_data_o, lcr_o;
  logic [15:0] div_o;
  logic        txrdy_n, rxrdy_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif uut (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i), .dat_o(dat_o),
    .ack_o(ack_o), .irq_o(irq_o), .rx_data_i(rx_data_i),
    .rx_valid_i(rx_valid_i), .rx_perr_i(rx_perr_i), .rx_ferr_i(rx_ferr_i),
    .tx_take_i(tx_take_i), .tx_data_o(tx_data_o), .lcr_o(lcr_o),
    .div_o(div_o), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  adr;
    logic [1:0]  sel;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // register-file walk; expected read values assume the reset state
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h7, 2'b11, 16'h0000, 16'h0036, 4'd3},  // R3 reset divisor
    '{1'b1, 4'h7, 2'b11, 16'h1234, 16'h0000, 4'd3},
    '{1'b0, 4'h7, 2'b11, 16'h0000, 16'h1234, 4'd3},  // R3 both lanes
    '{1'b1, 4'h7, 2'b01, 16'hFF56, 16'h0000, 4'd3},
    '{1'b0, 4'h7, 2'b11, 16'h0000, 16'h1256, 4'd3},  // R3 low lane only
    '{1'b1, 4'h7, 2'b10, 16'hAB00, 16'h0000, 4'd3},
    '{1'b0, 4'h7, 2'b11, 16'h0000, 16'hAB56, 4'd3},  // R3 high lane only
    '{1'b1, 4'h1, 2'b01, 16'h0005, 16'h0000, 4'd4},
    '{1'b0, 4'h1, 2'b01, 16'h0000, 16'h0005, 4'd4},  // R4 mask
    '{1'b1, 4'h1, 2'b00, 16'h0007, 16'h0000, 4'd4},
    '{1'b0, 4'h1, 2'b01, 16'h0000, 16'h0005, 4'd4},  // R4 no lane, no write
    '{1'b1, 4'h1, 2'b01, 16'h00FF, 16'h0000, 4'd4},
    '{1'b0, 4'h1, 2'b01, 16'h0000, 16'h0007, 4'd4},  // R4 3-bit mask
    '{1'b1, 4'h3, 2'b11, 16'hFF5A, 16'h0000, 4'd4},
    '{1'b0, 4'h3, 2'b01, 16'h0000, 16'h005A, 4'd2},  // R2 zero-extended
    '{1'b1, 4'h5, 2'b01, 16'h00FF, 16'h0000, 4'd4},
    '{1'b0, 4'h5, 2'b01, 16'h0000, 16'h0020, 4'd4},  // R4 read-only status
    '{1'b0, 4'h4, 2'b01, 16'h0000, 16'h0000, 4'd2},  // R2 unmapped
    '{1'b0, 4'hF, 2'b01, 16'h0000, 16'h0000, 4'd2},  // R2 unmapped
    '{1'b1, 4'h1, 2'b01, 16'h0000, 16'h0000, 4'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [3:0] adr, input logic [1:0] sel,
                     input logic [15:0] wd, input logic rx_with, input logic [7:0] rx_b,
                     output logic [15:0] rdat);
    int waited;
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = we; adr_i = adr; sel_i = sel; dat_i = wd;
    if (rx_with) begin rx_valid_i = 1; rx_data_i = rx_b; end
    waited = 0;
    do begin
      @(posedge clk); #1;
      rx_valid_i = 0;
      waited++;
    end while (!ack_o && waited < 20);
    rdat = dat_o;
    cyc_i = 0; stb_i = 0; we_i = 0; sel_i = '0;
    chk("R1 ack latency", waited, 1);
    @(posedge clk); #1;
    chk("R1 ack single cycle", ack_o, 0);
  endtask

  task automatic rx_pulse(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid_i = 1; rx_data_i = b; rx_perr_i = pe; rx_ferr_i = fe;
    @(negedge clk);
    rx_valid_i = 0; rx_perr_i = 0; rx_ferr_i = 0;
  endtask

  task automatic take_pulse();
    @(negedge clk); tx_take_i = 1;
    @(negedge clk); tx_take_i = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ack", ack_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 dat", dat_o, 0);
    chk("R10 txrdy_n", txrdy_n, 0);
    chk("R10 rxrdy_n", rxrdy_n, 1);
    chk("R10 lcr", lcr_o, 0);
    chk("R3 reset div", div_o, 16'h0036);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].we, VEC[i].adr, VEC[i].sel, VEC[i].wd, 1'b0, 8'h00, rd);
      if (!VEC[i].we)
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
    end
    chk("R4 lcr_o", lcr_o, 8'h5A);
    chk("R3 div_o", div_o, 16'hAB56);

    // R1 no acknowledge without both cyc and stb
    @(negedge clk); cyc_i = 0; stb_i = 1;
    repeat (3) begin @(negedge clk); chk("R1 stb only", ack_o, 0); end
    cyc_i = 1; stb_i = 0;
    repeat (3) begin @(negedge clk); chk("R1 cyc only", ack_o, 0); end
    cyc_i = 0;

    // R5 transmit holding register
    bus(1, 4'h8, 2'b10, 16'h00C3, 0, 0, rd);
    chk("R5 no low lane", txrdy_n, 0);
    bus(1, 4'h8, 2'b01, 16'h00C3, 0, 0, rd);
    chk("R5 txrdy_n after write", txrdy_n, 1);
    chk("R5 tx_data", tx_data_o, 8'hC3);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R5 status not empty", rd, 16'h0000);
    take_pulse();
    chk("R5 txrdy_n after take", txrdy_n, 0);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R5 status empty", rd, 16'h0020);

    // R6 receive path
    rx_pulse(8'h5C, 0, 0);
    chk("R6 rxrdy_n low", rxrdy_n, 0);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R6 data ready bit", rd, 16'h0021);
    bus(0, 4'h0, 2'b01, 0, 0, 0, rd);
    chk("R6 rx byte", rd, 16'h005C);
    chk("R6 rxrdy_n cleared", rxrdy_n, 1);

    // R7 overrun and error capture, read-to-clear
    rx_pulse(8'h11, 0, 0);
    rx_pulse(8'h22, 1, 0);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R7 overrun+parity", rd, 16'h0027);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R7 errors cleared", rd, 16'h0021);
    bus(0, 4'h0, 2'b01, 0, 0, 0, rd);
    chk("R7 latest byte kept", rd, 16'h0022);

    // R11 byte arriving during a buffer read
    rx_pulse(8'h33, 0, 0);
    bus(0, 4'h0, 2'b01, 0, 1, 8'h44, rd);
    chk("R11 old byte returned", rd, 16'h0033);
    chk("R11 data ready kept", rxrdy_n, 0);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R11 no overrun", rd, 16'h0021);
    bus(0, 4'h0, 2'b01, 0, 0, 0, rd);
    chk("R11 new byte", rd, 16'h0044);

    // R8 / R9 interrupts and priority
    settle();
    chk("R8 masked irq", irq_o, 0);
    bus(0, 4'h2, 2'b01, 0, 0, 0, rd);
    chk("R9 none pending", rd, 16'h0001);
    bus(1, 4'h1, 2'b01, 16'h0002, 0, 0, rd);
    settle();
    chk("R8 tx-empty irq", irq_o, 1);
    bus(0, 4'h2, 2'b01, 0, 0, 0, rd);
    chk("R9 tx-empty id", rd, 16'h0002);
    bus(1, 4'h8, 2'b01, 16'h0010, 0, 0, rd);
    settle();
    chk("R8 irq drops", irq_o, 0);
    bus(1, 4'h1, 2'b01, 16'h0007, 0, 0, rd);
    rx_pulse(8'h77, 0, 1);
    settle();
    chk("R8 line irq", irq_o, 1);
    bus(0, 4'h2, 2'b01, 0, 0, 0, rd);
    chk("R9 line error first", rd, 16'h0006);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R7 framing bit", rd, 16'h0009);
    bus(0, 4'h2, 2'b01, 0, 0, 0, rd);
    chk("R9 data ready next", rd, 16'h0004);
    bus(0, 4'h0, 2'b01, 0, 0, 0, rd);
    bus(0, 4'h2, 2'b01, 0, 0, 0, rd);
    chk("R9 none after read", rd, 16'h0001);
    settle();
    chk("R8 irq idle", irq_o, 0);
    take_pulse();
    bus(0, 4'h2, 2'b01, 0, 0, 0, rd);
    chk("R9 tx-empty last", rd, 16'h0002);
    chk("R8 irq from tx-empty", irq_o, 1);

    // R10 reset in mid-run
    rx_pulse(8'h99, 1, 1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R10 irq after reset", irq_o, 0);
    chk("R10 rxrdy_n after reset", rxrdy_n, 1);
    chk("R10 div after reset", div_o, 16'h0036);
    bus(0, 4'h1, 2'b01, 0, 0, 0, rd);
    chk("R10 mask cleared", rd, 16'h0000);
    bus(0, 4'h5, 2'b01, 0, 0, 0, rd);
    chk("R10 status cleared", rd, 16'h0020);

    summary();
  end
endmodule